// File: doc/BRIEF.md
# Registered Sixteen-Bit Opcode ALU

This block is a two-stage arithmetic and logic unit for 16-bit operands. On one rising clock edge it captures both operands, a carry-in bit and a 4-bit operation code into input registers. On the following edge it captures the computed word and three status bits into output registers. A consumer can therefore present a new operation on every cycle and collect each answer a fixed two edges later.

The operation code selects one of eleven functions:
- addition with carry and subtraction;
- equality and inequality tests;
- five bitwise logic functions;
- forwarding of either operand unchanged.

The five spare codes produce an all-zero output, flags included. All state is cleared by an active-high synchronous reset.

Top module: `alu16_top`

## Requirements
- R1: Code 4'h0 yields opA + opB + carryIn, truncated to 16 bits, with carryOut equal to bit 16 of the sum.
- R2: Code 4'h1 yields opA - opB (computed as opA + ~opB + 1). carryOut is 1 when no borrow occurs. carryIn has no effect on this code.
- R3: Code 4'h2 drives cmpOut high exactly when opA equals opB. The result word and carryOut are zero.
- R4: Code 4'h3 drives cmpOut high exactly when opA differs from opB. The result word and carryOut are zero.
- R5: Codes 4'h4, 4'h5, 4'h6 and 4'h7 give bitwise XOR, NOR, OR and AND of the operands.
- R6: Code 4'h8 forwards opA, code 4'h9 forwards opB, and code 4'hA gives bitwise NAND.
- R7: Codes 4'hB to 4'hF drive result, carryOut, cmpOut and zeroFlag all to zero.
- R8: On every defined code, zeroFlag is high exactly when the registered result word is zero.
- R9: An operation whose inputs are present at clock edge k has its outputs registered at edge k+1, with one new operation accepted per cycle.
- R10: While rst is high at a clock edge, every input and output register clears, so result, carryOut, cmpOut and zeroFlag all read zero.
- R11: carryOut is zero for every code other than 4'h0 and 4'h1. cmpOut is zero for every code other than 4'h2 and 4'h3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry input for addition |
| opcode | input | 4 | Operation select |
| result | output | 16 | Registered result word |
| carryOut | output | 1 | Registered carry / not-borrow |
| cmpOut | output | 1 | Registered compare outcome |
| zeroFlag | output | 1 | Registered zero indication |

## Verification
Every output reflects the operation whose inputs were on the pins two rising edges earlier: one edge captures the inputs and the next loads the outputs. The bench drives a fresh operation at each falling edge. It keeps the expected values of the two operations still in flight in a short shift chain, so each comparison falls on the falling edge after the edge that loaded the result. Back-to-back operations with different codes therefore also confirm that no answer arrives early, late or mixed with a neighbour. Reset checks are sampled at the falling edge after the reset edge.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  localparam int unsigned OP_W = 4;

  localparam logic [OP_W-1:0] OP_ADD   = 4'h0;
  localparam logic [OP_W-1:0] OP_SUB   = 4'h1;
  localparam logic [OP_W-1:0] OP_EQ    = 4'h2;
  localparam logic [OP_W-1:0] OP_NE    = 4'h3;
  localparam logic [OP_W-1:0] OP_XOR   = 4'h4;
  localparam logic [OP_W-1:0] OP_NOR   = 4'h5;
  localparam logic [OP_W-1:0] OP_OR    = 4'h6;
  localparam logic [OP_W-1:0] OP_AND   = 4'h7;
  localparam logic [OP_W-1:0] OP_PASSA = 4'h8;
  localparam logic [OP_W-1:0] OP_PASSB = 4'h9;
  localparam logic [OP_W-1:0] OP_NAND  = 4'hA;

  typedef enum logic [3:0] {
    SEL_ARITH,
    SEL_XOR,
    SEL_NOR,
    SEL_OR,
    SEL_AND,
    SEL_PASSA,
    SEL_PASSB,
    SEL_NAND,
    SEL_NONE
  } resSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    resSel_e resSel;
    logic    subMode;  // invert B and force carry-in
    logic    cmpEn;    // compare result drives cmpOut
    logic    cmpInv;   // report inequality instead of equality
    logic    kill;     // spare code: suppress every flag
  } ctrlStrobe_t;

endpackage

// File: rtl/alu16_ctrl.sv
module alu16_ctrl
  import alu16_pkg::*;
(
  input  logic [OP_W-1:0] opQ,
  output ctrlStrobe_t     strobe
);

  always_comb begin
    strobe = '{resSel: SEL_NONE, subMode: 1'b0, cmpEn: 1'b0, cmpInv: 1'b0, kill: 1'b0};
    unique case (opQ)
      OP_ADD:   strobe.resSel = SEL_ARITH;
      OP_SUB: begin
        strobe.resSel  = SEL_ARITH;
        strobe.subMode = 1'b1;
      end
      OP_EQ:    strobe.cmpEn = 1'b1;
      OP_NE: begin
        strobe.cmpEn  = 1'b1;
        strobe.cmpInv = 1'b1;
      end
      OP_XOR:   strobe.resSel = SEL_XOR;
      OP_NOR:   strobe.resSel = SEL_NOR;
      OP_OR:    strobe.resSel = SEL_OR;
      OP_AND:   strobe.resSel = SEL_AND;
      OP_PASSA: strobe.resSel = SEL_PASSA;
      OP_PASSB: strobe.resSel = SEL_PASSB;
      OP_NAND:  strobe.resSel = SEL_NAND;
      default:  strobe.kill = 1'b1;
    endcase
  end

endmodule

// File: rtl/alu16_dp.sv
module alu16_dp
  import alu16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             cinIn,
  input  logic [OP_W-1:0]  opIn,
  input  ctrlStrobe_t      strobe,
  output logic [OP_W-1:0]  opQ,
  output logic [WIDTH-1:0] aQ,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             cmpOut,
  output logic             zeroFlag
);

  localparam int unsigned SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] bQ;
  logic             cinQ;

  // Input stage
  always_ff @(posedge clk) begin
    if (rst) begin
      aQ   <= '0;
      bQ   <= '0;
      cinQ <= 1'b0;
      opQ  <= '0;
    end else begin
      aQ   <= aIn;
      bQ   <= bIn;
      cinQ <= cinIn;
      opQ  <= opIn;
    end
  end

  // Adder shared by add and subtract
  logic [WIDTH-1:0] bOperand;
  logic             carryInEff;
  logic [SUM_W-1:0] sumFull;

  assign bOperand   = strobe.subMode ? ~bQ : bQ;
  assign carryInEff = strobe.subMode ? 1'b1 : cinQ;
  assign sumFull    = {1'b0, aQ} + {1'b0, bOperand} + {{WIDTH{1'b0}}, carryInEff};

  // Per-bit difference vector for the comparator
  logic [WIDTH-1:0] diffBits;
  for (genvar i = 0; i < WIDTH; i++) begin : g_diff
    assign diffBits[i] = aQ[i] ^ bQ[i];
  end
  logic isEqual;
  assign isEqual = ~|diffBits;

  logic [WIDTH-1:0] resNext;
  logic             coNext;
  logic             cmpNext;
  logic             zNext;

  always_comb begin
    unique case (strobe.resSel)
      SEL_ARITH: resNext = sumFull[WIDTH-1:0];
      SEL_XOR:   resNext = diffBits;
      SEL_NOR:   resNext = ~(aQ | bQ);
      SEL_OR:    resNext = aQ | bQ;
      SEL_AND:   resNext = aQ & bQ;
      SEL_PASSA: resNext = aQ;
      SEL_PASSB: resNext = bQ;
      SEL_NAND:  resNext = ~(aQ & bQ);
      default:   resNext = '0;
    endcase
    coNext  = (strobe.resSel == SEL_ARITH) ? sumFull[WIDTH] : 1'b0;
    cmpNext = strobe.cmpEn ? (isEqual ^ strobe.cmpInv) : 1'b0;
    zNext   = !strobe.kill && (resNext == '0);
  end

  // Output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      carryOut <= 1'b0;
      cmpOut   <= 1'b0;
      zeroFlag <= 1'b0;
    end else begin
      result   <= resNext;
      carryOut <= coNext;
      cmpOut   <= cmpNext;
      zeroFlag <= zNext;
    end
  end

endmodule

// File: rtl/alu16_top.sv
module alu16_top
  import alu16_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  input  logic [3:0]       opcode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             cmpOut,
  output logic             zeroFlag
);

  ctrlStrobe_t      strobe;
  logic [OP_W-1:0]  opReg;
  logic [WIDTH-1:0] aReg;

  alu16_ctrl u_ctrl (
    .opQ    (opReg),
    .strobe (strobe)
  );

  alu16_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .aIn      (opA),
    .bIn      (opB),
    .cinIn    (carryIn),
    .opIn     (opcode),
    .strobe   (strobe),
    .opQ      (opReg),
    .aQ       (aReg),
    .result   (result),
    .carryOut (carryOut),
    .cmpOut   (cmpOut),
    .zeroFlag (zeroFlag)
  );

endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       opReg,
  input logic [WIDTH-1:0] aReg,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             cmpOut,
  input logic             zeroFlag
);

  p_spare_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (opReg >= 4'hB) |=> (result == '0 && !carryOut && !cmpOut && !zeroFlag));

  p_zero_means_zero_r8: assert property (@(posedge clk) disable iff (rst)
    zeroFlag |-> (result == '0));

  p_cmp_clean_r11: assert property (@(posedge clk) disable iff (rst)
    cmpOut |-> (result == '0 && !carryOut));

  p_pass_a_r6: assert property (@(posedge clk) disable iff (rst)
    (opReg == 4'h8) |=> (result == $past(aReg)));

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (result == '0 && !carryOut && !cmpOut && !zeroFlag));

endmodule

bind alu16_top alu16_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opReg    (opReg),
  .aReg     (aReg),
  .result   (result),
  .carryOut (carryOut),
  .cmpOut   (cmpOut),
  .zeroFlag (zeroFlag)
);

// File: tb/alu16_top_test.sv
`timescale 1ns/1ps
module alu16_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [3:0]  opcode = '0;
  logic [15:0] result;
  logic        carryOut;
  logic        cmpOut;
  logic        zeroFlag;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  alu16_top uut (
    .clk(clk), .rst(rst), .opA(opA), .opB(opB), .carryIn(carryIn),
    .opcode(opcode), .result(result), .carryOut(carryOut),
    .cmpOut(cmpOut), .zeroFlag(zeroFlag)
  );

  // Expected value packed as {result, carryOut, cmpOut, zeroFlag}
  function automatic logic [18:0] model(input logic [15:0] a, input logic [15:0] b,
                                        input logic cin, input logic [3:0] op);
    logic [16:0] s;
    logic [15:0] r;
    logic c;
    logic m;
    s = '0; r = '0; c = 0; m = 0;
    case (op)
      4'h0: begin s = 17'(a) + 17'(b) + 17'(cin); r = s[15:0]; c = s[16]; end
      4'h1: begin r = a - b; c = (a >= b); end
      4'h2: m = (a == b);
      4'h3: m = (a != b);
      4'h4: r = a ^ b;
      4'h5: r = ~(a | b);
      4'h6: r = a | b;
      4'h7: r = a & b;
      4'h8: r = a;
      4'h9: r = b;
      4'hA: r = ~(a & b);
      default: ;
    endcase
    return {r, c, m, (op <= 4'hA) && (r == 16'h0)};
  endfunction

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'h0: return "R1";
      4'h1: return "R2";
      4'h2: return "R3";
      4'h3: return "R4";
      4'h4, 4'h5, 4'h6, 4'h7: return "R5";
      4'h8, 4'h9, 4'hA: return "R6";
      default: return "R7";
    endcase
  endfunction

  logic [18:0] e1, e2;
  string t1, t2;
  bit v1 = 0, v2 = 0;

  task automatic checkOut(input logic [18:0] exp, input string tag);
    logic [18:0] act;
    act = {result, carryOut, cmpOut, zeroFlag};
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got res=%h co=%b cmp=%b z=%b expected res=%h co=%b cmp=%b z=%b",
               tag, act[18:3], act[2], act[1], act[0], exp[18:3], exp[2], exp[1], exp[0]);
    end
  endtask

  // Drive one operation; check the one presented two falling edges ago (R9)
  task automatic pushVec(input logic [15:0] a, input logic [15:0] b, input logic cin,
                         input logic [3:0] op, input string tag);
    @(negedge clk);
    if (v2) checkOut(e2, t2);
    e2 = e1; t2 = t1; v2 = v1;
    e1 = model(a, b, cin, op); t1 = tag; v1 = 1;
    opA = a; opB = b; carryIn = cin; opcode = op;
  endtask

  task automatic flushPipe();
    repeat (2) begin
      @(negedge clk);
      if (v2) checkOut(e2, t2);
      e2 = e1; t2 = t1; v2 = v1; v1 = 0;
    end
    v2 = 0;
  endtask

  // R10: reset clears all registers even with busy inputs
  task automatic doReset();
    v1 = 0; v2 = 0;
    @(negedge clk);
    rst = 1; opA = 16'hFFFF; opB = 16'h0001; opcode = 4'h0; carryIn = 1;
    @(negedge clk);
    checkOut(19'h0, "R10");
    @(negedge clk);
    checkOut(19'h0, "R10");
    rst = 0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5eed);
    repeat (2) @(negedge clk);
    checkOut(19'h0, "R10 reset state");
    rst = 0;

    // R1 directed: full carry chain and carry-in
    pushVec(16'hFFFF, 16'h0001, 1'b0, 4'h0, "R1 carry chain");
    pushVec(16'h00FF, 16'h0001, 1'b1, 4'h0, "R1 carry-in");
    // R2: subtraction, borrow, carry-in ignored
    pushVec(16'hAAAA, 16'h1555, 1'b0, 4'h1, "R2 sub");
    pushVec(16'hAAAA, 16'h1555, 1'b1, 4'h1, "R2 sub cin ignored");
    pushVec(16'h0001, 16'h0002, 1'b1, 4'h1, "R2 borrow");
    pushVec(16'h1234, 16'h1234, 1'b0, 4'h1, "R2 R8 zero difference");
    // R3 / R4 compares
    pushVec(16'h5A5A, 16'h5A5A, 1'b1, 4'h2, "R3 equal");
    pushVec(16'h5A5A, 16'h5A5B, 1'b0, 4'h2, "R3 unequal");
    pushVec(16'h5555, 16'hAAAA, 1'b0, 4'h3, "R4 differ");
    pushVec(16'h8000, 16'h8000, 1'b1, 4'h3, "R4 same");
    // R5 / R6 logic and pass
    pushVec(16'h5555, 16'hAAAA, 1'b0, 4'h4, "R5 xor");
    pushVec(16'h0F0F, 16'h00FF, 1'b1, 4'h5, "R5 nor R11");
    pushVec(16'h0F0F, 16'h00FF, 1'b0, 4'h6, "R5 or");
    pushVec(16'h0F0F, 16'hF0F0, 1'b0, 4'h7, "R5 and R8");
    pushVec(16'hC3C3, 16'h1111, 1'b0, 4'h8, "R6 pass A");
    pushVec(16'hC3C3, 16'h1111, 1'b0, 4'h9, "R6 pass B");
    pushVec(16'h6666, 16'h0000, 1'b0, 4'hA, "R6 nand");
    // R7: every spare code
    for (int op = 11; op < 16; op++)
      pushVec(16'hFFFF, 16'h0001, 1'b1, 4'(op), "R7 spare code");
    // R9: alternating codes back to back
    pushVec(16'h0000, 16'h0000, 1'b0, 4'h0, "R9 back-to-back");
    pushVec(16'hFFFF, 16'hFFFF, 1'b1, 4'h0, "R9 back-to-back");
    pushVec(16'h0000, 16'h0000, 1'b0, 4'h2, "R9 back-to-back");
    flushPipe();

    doReset();

    // Constrained random mix across all codes
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      logic [3:0] op;
      a = 16'($urandom);
      b = (i % 5 == 0) ? a : 16'($urandom);
      op = 4'($urandom % 16);
      pushVec(a, b, 1'($urandom), op, reqOf(op));
    end
    flushPipe();
    doReset();

    finished = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule